// File: doc/BRIEF.md
# Receive Out-of-Band Mailbox Register

This block holds the 32-bit side-channel word carried in received frames. The receive path gives it that word together with a one-cycle strobe per frame. Software reads the held word as two 16-bit halves. Each half has a read strobe that starts the side effects of reading it.

Reading the low half locks the register. After that, new frames cannot change the word until the high half is read. Reading the high half releases the lock and clears the valid flag, so the two 16-bit reads always return one consistent 32-bit value. A non-zero captured word sets the valid flag. The block presents that flag as a level interrupt request. Interrupt masking is left to the surrounding logic.

Top module: `rx_oob_mailbox`

## Requirements
- R1: After synchronous reset the held word is 0x0000_0000, the valid flag and the interrupt request are 0, and the register is unlocked.
- R2: When the register is unlocked and no read strobe is active, a frame strobe loads that frame's side word. The new word appears on the two read halves one cycle later, with bits [15:0] on the low half and bits [31:16] on the high half.
- R3: Capturing a non-zero side word sets the valid flag, visible one cycle after the strobe.
- R4: Capturing a zero side word still loads the register, and the valid flag keeps its previous value.
- R5: A low-half read strobe without a high-half read strobe locks the register from that same cycle. Any frame in that cycle, and any frame in later cycles, is dropped: both the held word and the valid flag stay unchanged.
- R6: A high-half read strobe unlocks the register and clears the valid flag one cycle later, unless the case in R7 applies.
- R7: A frame strobe in the same cycle as a high-half read is captured, because the unlock takes effect first. The valid flag ends at 1 if that word is non-zero. If the word is zero, the flag is cleared.
- R8: Low-half and high-half read strobes in the same cycle act as a high-half read, so the register ends unlocked.
- R9: The interrupt request output always equals the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle strobe: a frame's side word is present |
| frm_word | input | 32 | Side word of the current frame |
| rd_lo_stb | input | 1 | Software is reading the low half |
| rd_hi_stb | input | 1 | Software is reading the high half |
| rd_lo_data | output | 16 | Low half of the held word |
| rd_hi_data | output | 16 | High half of the held word |
| rx_valid | output | 1 | Valid flag: a non-zero word was captured |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that:
- reset clears the word and the flag;
- an unlocked frame with no read strobe is loaded;
- a non-zero capture raises the flag;
- a zero capture leaves the flag alone;
- a low read locks the register;
- a locked register keeps its word;
- a high read with no non-zero capture clears the flag and the lock.

Only the bench scenarios show the longer sequences: a coherent pair of halves across a low read, many dropped frames, and a high read. They also cover the same-cycle collisions of a frame with a high read or with both read strobes, and long random mixes where the bench model tracks the lock state.

// File: rtl/rx_oob_mailbox_pkg.sv
package rx_oob_mailbox_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic load;      // write the frame word into the holder
        logic set_flag;  // captured word is non-zero
        logic clr_flag;  // high half read
        logic lock_nxt;  // lock state for the next cycle
    } mb_ctl_t;

    function automatic logic word_nonnull(input logic [WORD_W-1:0] w);
        return |w;
    endfunction
endpackage

// File: rtl/rx_oob_lock_ctl.sv
module rx_oob_lock_ctl
    import rx_oob_mailbox_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frm_stb,
    input  logic [W-1:0] frm_word,
    input  logic         rd_lo_stb,
    input  logic         rd_hi_stb,
    output logic         locked,
    output mb_ctl_t      ctl
);
    logic accept;

    always_comb begin
        // unlock by a high read comes first; a low read freezes at once
        accept       = rd_hi_stb || (!locked && !rd_lo_stb);
        ctl.load     = frm_stb && accept;
        ctl.set_flag = ctl.load && word_nonnull(frm_word);
        ctl.clr_flag = rd_hi_stb;
        if (rd_hi_stb)
            ctl.lock_nxt = 1'b0;
        else if (rd_lo_stb)
            ctl.lock_nxt = 1'b1;
        else
            ctl.lock_nxt = locked;
    end

    always_ff @(posedge clk) begin
        if (rst) locked <= 1'b0;
        else     locked <= ctl.lock_nxt;
    end
endmodule

// File: rtl/rx_oob_hold_reg.sv
module rx_oob_hold_reg #(
    parameter int HW    = 16,
    parameter int NHALF = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [HW*NHALF-1:0] din,
    output logic [HW*NHALF-1:0] dout
);
    for (genvar g = 0; g < NHALF; g++) begin : g_half
        logic [HW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)       q <= '0;
            else if (load) q <= din[g*HW +: HW];
        end
        assign dout[g*HW +: HW] = q;
    end
endmodule

// File: rtl/rx_oob_flag.sv
module rx_oob_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_flag,
    input  logic clr_flag,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (set_flag) flag <= 1'b1;
        else if (clr_flag) flag <= 1'b0;
    end
endmodule

// File: rtl/rx_oob_mailbox.sv
module rx_oob_mailbox
    import rx_oob_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_stb,
    input  logic [WORD_W-1:0] frm_word,
    input  logic              rd_lo_stb,
    input  logic              rd_hi_stb,
    output logic [HALF_W-1:0] rd_lo_data,
    output logic [HALF_W-1:0] rd_hi_data,
    output logic              rx_valid,
    output logic              irq
);
    mb_ctl_t           ctl;
    logic              locked;
    logic [WORD_W-1:0] held;

    rx_oob_lock_ctl #(.W(WORD_W)) u_ctl (
        .clk(clk), .rst(rst), .frm_stb(frm_stb), .frm_word(frm_word),
        .rd_lo_stb(rd_lo_stb), .rd_hi_stb(rd_hi_stb),
        .locked(locked), .ctl(ctl)
    );

    rx_oob_hold_reg #(.HW(HALF_W), .NHALF(2)) u_hold (
        .clk(clk), .rst(rst), .load(ctl.load), .din(frm_word), .dout(held)
    );

    rx_oob_flag u_flag (
        .clk(clk), .rst(rst), .set_flag(ctl.set_flag),
        .clr_flag(ctl.clr_flag), .flag(rx_valid)
    );

    assign rd_lo_data = held[HALF_W-1:0];
    assign rd_hi_data = held[WORD_W-1:HALF_W];
    assign irq        = rx_valid;
endmodule

// File: rtl/rx_oob_mailbox_chk.sv
module rx_oob_mailbox_chk
    import rx_oob_mailbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frm_stb,
    input logic [WORD_W-1:0] frm_word,
    input logic              rd_lo_stb,
    input logic              rd_hi_stb,
    input logic [HALF_W-1:0] rd_lo_data,
    input logic [HALF_W-1:0] rd_hi_data,
    input logic              rx_valid,
    input logic              locked
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_lo_data == '0 && rd_hi_data == '0 && !rx_valid && !locked));

    // R2
    open_load_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_stb && !locked && !rd_lo_stb && !rd_hi_stb)
        |=> {rd_hi_data, rd_lo_data} == $past(frm_word));

    // R3
    nonnull_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_stb && (rd_hi_stb || (!locked && !rd_lo_stb)) && frm_word != '0)
        |=> rx_valid);

    // R4
    null_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_stb && frm_word == '0 && !rd_hi_stb) |=> rx_valid == $past(rx_valid));

    // R5
    lo_read_locks_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_lo_stb && !rd_hi_stb) |=> locked);

    // R5
    frozen_word_chk: assert property (@(posedge clk) disable iff (rst)
        ((locked || rd_lo_stb) && !rd_hi_stb)
        |=> ($stable(rd_lo_data) && $stable(rd_hi_data) && $stable(rx_valid)));

    // R6
    hi_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hi_stb && !(frm_stb && frm_word != '0)) |=> (!rx_valid && !locked));
endmodule

bind rx_oob_mailbox rx_oob_mailbox_chk u_chk (
    .clk(clk), .rst(rst), .frm_stb(frm_stb), .frm_word(frm_word),
    .rd_lo_stb(rd_lo_stb), .rd_hi_stb(rd_hi_stb),
    .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data),
    .rx_valid(rx_valid), .locked(locked)
);

// File: tb/tb_rx_oob_mailbox.sv
module tb_rx_oob_mailbox;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_stb = 1'b0;
    logic [31:0] frm_word = '0;
    logic        rd_lo_stb = 1'b0;
    logic        rd_hi_stb = 1'b0;
    logic [15:0] rd_lo_data, rd_hi_data;
    logic        rx_valid, irq;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state
    logic [31:0] m_word = '0;
    logic        m_flag = 1'b0;
    logic        m_lock = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rx_oob_mailbox dut (
        .clk(clk), .rst(rst), .frm_stb(frm_stb), .frm_word(frm_word),
        .rd_lo_stb(rd_lo_stb), .rd_hi_stb(rd_hi_stb),
        .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data),
        .rx_valid(rx_valid), .irq(irq)
    );

    function automatic logic model_accept(input logic lk, input logic lo, input logic hi);
        return hi || (!lk && !lo);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " word"}, {rd_hi_data, rd_lo_data}, m_word);
        check({req, " flag"}, {31'd0, rx_valid}, {31'd0, m_flag});
        check("R9 irq", {31'd0, irq}, {31'd0, m_flag});
    endtask

    // drive one cycle at negedge, update the model, sample at the next negedge
    task automatic cyc(input logic f, input logic [31:0] w, input logic lo, input logic hi,
                       input string req);
        logic ld;
        @(negedge clk);
        frm_stb = f; frm_word = w; rd_lo_stb = lo; rd_hi_stb = hi;
        ld = f && model_accept(m_lock, lo, hi);
        if (ld) m_word = w;
        if (ld && (w != 0)) m_flag = 1'b1;
        else if (hi)        m_flag = 1'b0;
        if (hi)      m_lock = 1'b0;
        else if (lo) m_lock = 1'b1;
        @(negedge clk);
        frm_stb = 1'b0; rd_lo_stb = 1'b0; rd_hi_stb = 1'b0;
        check_all(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        // R2, R3: unlocked non-zero capture
        cyc(1, 32'hDEAD_BEEF, 0, 0, "R2");
        // R4: zero capture loads, flag stays 1
        cyc(1, 32'h0, 0, 0, "R4");
        // R6: high read clears flag
        cyc(0, 0, 0, 1, "R6");
        // R4: zero capture with flag 0 keeps it 0
        cyc(1, 32'h0, 0, 0, "R4");
        cyc(1, 32'h1234_5678, 0, 0, "R3");
        // R5: low read with same-cycle frame drops the frame
        cyc(1, 32'hAAAA_5555, 1, 0, "R5");
        cyc(1, 32'hFFFF_0000, 0, 0, "R5");
        cyc(1, 32'h0, 0, 0, "R5");
        // R7: frame with high read is captured
        cyc(1, 32'h0BAD_F00D, 0, 1, "R7");
        cyc(0, 0, 1, 0, "R5");
        // R7: zero frame with high read leaves flag cleared
        cyc(1, 32'h0, 0, 1, "R7");
        // R8: both strobes act as a high read
        cyc(0, 0, 1, 0, "R8");
        cyc(0, 0, 1, 1, "R8");
        cyc(1, 32'hC0DE_0001, 0, 0, "R8");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic f, lo, hi;
            logic [31:0] w;
            f  = ($urandom % 100) < 45;
            lo = ($urandom % 100) < 15;
            hi = ($urandom % 100) < 10;
            w  = (($urandom % 100) < 25) ? 32'h0 : $urandom;
            cyc(f, w, lo, hi, "R2,R5,R7");
        end

        // R1: reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_word = '0; m_flag = 1'b0; m_lock = 1'b0;
        check_all("R1 reset");
        cyc(1, 32'h0000_0042, 0, 0, "R1 unlocked");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule